// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a relative-time alarm driven by a one-second tick. Software loads the number of seconds to wait. While the alarm is enabled, each tick takes one off the remaining count. The tick that brings the count to zero latches a sticky pending flag, and counting then stops at zero. The pending flag drives an interrupt line when the interrupt gate is open. It separately drives a wake-up request when the wake-up gate is open. Software clears the flag by writing a one to it.

Access goes through a simple word-wide register port. Writes take effect on the clock edge. Reads are combinational from the address. A load register holds the last loaded gap, and a separate read-only location returns the live remaining count.

Software re-arms the alarm in this order: clear the enable, write zero to the load register, wait a short settling time, write the new gap, then enable again. A count of zero never raises the flag, so the intermediate zero load is harmless.

Top module: `sec_alarm`

## Requirements
- R1: A write to offset 0x20 stores a 32-bit value, reads back at 0x20, and copies the value into the remaining count on the same edge. A load in the same cycle as a tick takes priority, and the tick is dropped.
- R2: Offset 0x24 returns the remaining count.
- R3: Bit 0 of offset 0x28 is the count enable. When it is 1, every cycle with the tick input high reduces a nonzero count by exactly one. When it is 0, ticks leave the count unchanged.
- R4: The enabled tick that takes the count from 1 to 0 sets the pending flag, which is bit 0 of offset 0x30. The count then remains 0 under further ticks. Ticks on a count that is already 0 never set the flag.
- R5: Writing 1 to bit 0 of offset 0x30 clears the pending flag, and writing 0 there has no effect. If a set and a clear fall in the same cycle, the flag stays set.
- R6: The interrupt output equals the pending flag ANDed with bit 0 of offset 0x2C.
- R7: The wake output equals the pending flag ANDed with bit 0 of offset 0x50.
- R8: After reset every register reads 0 and both outputs are low. The single-bit registers read back only bit 0, with the upper bits 0. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sec_tick_i | input | 1 | One-cycle pulse once per second |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W (8) | Register byte offset |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Combinational read data for bus_addr_i |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
The assertions take the tick as a single-cycle strobe that is sampled on the clock edge like any other synchronous input. They also assume that a load and a tick may coincide, and that a status clear may land on the same edge as the zero-reaching tick. The step and hold properties therefore exclude load cycles explicitly, and the flag properties name both causes. The stimulus drives every input on the falling edge, so each write and tick is held for exactly one rising edge. It deliberately produces the colliding cases in directed form, then again at random against a behavioural model of the count and flag.

// File: rtl/sec_alarm_pkg.sv
package sec_alarm_pkg;

  parameter logic [7:0] OFF_LOAD = 8'h20;
  parameter logic [7:0] OFF_CUR  = 8'h24;
  parameter logic [7:0] OFF_EN   = 8'h28;
  parameter logic [7:0] OFF_IE   = 8'h2C;
  parameter logic [7:0] OFF_STAT = 8'h30;
  parameter logic [7:0] OFF_WAKE = 8'h50;

  typedef struct packed {
    logic load_we;
    logic en_we;
    logic ie_we;
    logic stat_we;
    logic wake_we;
  } wr_strobe_t;

endpackage

// File: rtl/sec_alarm_rst_sync.sv
module sec_alarm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/sec_alarm_decode.sv
module sec_alarm_decode
  import sec_alarm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_strobe_t        strb_o
);

  always_comb begin
    strb_o         = '0;
    strb_o.load_we = we_i && (addr_i == ADDR_W'(OFF_LOAD));
    strb_o.en_we   = we_i && (addr_i == ADDR_W'(OFF_EN));
    strb_o.ie_we   = we_i && (addr_i == ADDR_W'(OFF_IE));
    strb_o.stat_we = we_i && (addr_i == ADDR_W'(OFF_STAT));
    strb_o.wake_we = we_i && (addr_i == ADDR_W'(OFF_WAKE));
  end

endmodule

// File: rtl/sec_alarm_counter.sv
module sec_alarm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_en_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] load_q_o,
  output logic [CNT_W-1:0] cur_q_o,
  output logic             hit_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] load_q, load_d;
  logic [CNT_W-1:0] cur_q, cur_d;
  logic             step;

  assign step = tick_i && cnt_en_i && (cur_q != '0);

  always_comb begin
    load_d = load_q;
    cur_d  = cur_q;
    hit_o  = 1'b0;
    if (load_we_i) begin
      load_d = load_val_i;
      cur_d  = load_val_i;
    end else if (step) begin
      cur_d = cur_q - ONE;
      hit_o = (cur_q == ONE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      cur_q  <= '0;
    end else begin
      load_q <= load_d;
      cur_q  <= cur_d;
    end
  end

  assign load_q_o = load_q;
  assign cur_q_o  = cur_q;

  // R1
  load_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_i |=> (cur_q == $past(load_val_i)));

  // R3
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_en_i && !load_we_i && cur_q != '0) |=> (cur_q == $past(cur_q) - ONE));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_we_i && !(tick_i && cnt_en_i)) |=> $stable(cur_q));

  // R4
  zero_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == '0 && !load_we_i) |=> (cur_q == '0));

endmodule

// File: rtl/sec_alarm_ctrl.sv
module sec_alarm_ctrl
  import sec_alarm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  wr_strobe_t strb_i,
  input  logic       wbit_i,
  input  logic       hit_i,
  output logic       cnt_en_o,
  output logic       irq_en_o,
  output logic       wake_en_o,
  output logic       pend_o,
  output logic       irq_o,
  output logic       wake_o
);

  logic en_q, en_d;
  logic ie_q, ie_d;
  logic wk_q, wk_d;
  logic pend_q, pend_d;
  logic clr;

  assign clr = strb_i.stat_we && wbit_i;

  always_comb begin
    en_d   = strb_i.en_we   ? wbit_i : en_q;
    ie_d   = strb_i.ie_we   ? wbit_i : ie_q;
    wk_d   = strb_i.wake_we ? wbit_i : wk_q;
    pend_d = pend_q;
    if (hit_i)    pend_d = 1'b1;
    else if (clr) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      wk_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      ie_q   <= ie_d;
      wk_q   <= wk_d;
      pend_q <= pend_d;
    end
  end

  assign cnt_en_o  = en_q;
  assign irq_en_o  = ie_q;
  assign wake_en_o = wk_q;
  assign pend_o    = pend_q;
  assign irq_o     = pend_q && ie_q;
  assign wake_o    = pend_q && wk_q;

  // R4
  pend_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(hit_i));

  // R5
  pend_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> $past(clr));

  // R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> pend_q);

endmodule

// File: rtl/sec_alarm.sv
module sec_alarm
  import sec_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_tick_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              wake_o
);

  localparam int PAD_W = DATA_W - 1;

  logic             rst_n_int;
  wr_strobe_t       strb;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cur_q;
  logic             hit;
  logic             cnt_en;
  logic             irq_en;
  logic             wake_en;
  logic             pend;

  sec_alarm_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  sec_alarm_decode #(.ADDR_W(ADDR_W)) u_dec (
    .we_i   (bus_we_i),
    .addr_i (bus_addr_i),
    .strb_o (strb)
  );

  sec_alarm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .tick_i     (sec_tick_i),
    .cnt_en_i   (cnt_en),
    .load_we_i  (strb.load_we),
    .load_val_i (bus_wdata_i[CNT_W-1:0]),
    .load_q_o   (load_q),
    .cur_q_o    (cur_q),
    .hit_o      (hit)
  );

  sec_alarm_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .strb_i    (strb),
    .wbit_i    (bus_wdata_i[0]),
    .hit_i     (hit),
    .cnt_en_o  (cnt_en),
    .irq_en_o  (irq_en),
    .wake_en_o (wake_en),
    .pend_o    (pend),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(OFF_LOAD))      bus_rdata_o = DATA_W'(load_q);
    else if (bus_addr_i == ADDR_W'(OFF_CUR))  bus_rdata_o = DATA_W'(cur_q);
    else if (bus_addr_i == ADDR_W'(OFF_EN))   bus_rdata_o = {{PAD_W{1'b0}}, cnt_en};
    else if (bus_addr_i == ADDR_W'(OFF_IE))   bus_rdata_o = {{PAD_W{1'b0}}, irq_en};
    else if (bus_addr_i == ADDR_W'(OFF_STAT)) bus_rdata_o = {{PAD_W{1'b0}}, pend};
    else if (bus_addr_i == ADDR_W'(OFF_WAKE)) bus_rdata_o = {{PAD_W{1'b0}}, wake_en};
  end

endmodule

// File: tb/sec_alarm_tb_top.sv
module sec_alarm_tb_top;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic        wake;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural reference state
  logic [31:0] m_load, m_cur;
  bit m_en, m_ie, m_wk, m_pend;

  sec_alarm dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sec_tick_i  (tick),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq),
    .wake_o      (wake)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_load = 0; m_cur = 0; m_en = 0; m_ie = 0; m_wk = 0; m_pend = 0;
    end else begin
      bit set_p;
      bit clr_p;
      set_p = 0;
      clr_p = we && addr == 8'h30 && wdata[0];
      if (we && addr == 8'h20) begin
        m_load = wdata;
        m_cur  = wdata;
      end else if (tick && m_en && m_cur != 0) begin
        if (m_cur == 1) set_p = 1;
        m_cur = m_cur - 1;
      end
      if (we && addr == 8'h28) m_en = wdata[0];
      if (we && addr == 8'h2C) m_ie = wdata[0];
      if (we && addr == 8'h50) m_wk = wdata[0];
      if (set_p) m_pend = 1;
      else if (clr_p) m_pend = 0;
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h20:   return m_load;
      8'h24:   return m_cur;
      8'h28:   return {31'd0, m_en};
      8'h2C:   return {31'd0, m_ie};
      8'h30:   return {31'd0, m_pend};
      8'h50:   return {31'd0, m_wk};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h20:   return "R1";
      8'h24:   return "R2";
      8'h28:   return "R3";
      8'h2C:   return "R6";
      8'h30:   return "R5";
      8'h50:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    #1;
    if (!done) begin
      check("R6 irq", {31'd0, irq}, {31'd0, m_pend && m_ie});
      check("R7 wake", {31'd0, wake}, {31'd0, m_pend && m_wk});
      check(tag_of(addr), rdata, model_read(addr));
    end
  end

  task automatic drive(input bit w, input logic [7:0] a, input logic [31:0] d, input bit t);
    @(negedge clk);
    we = w; addr = a; wdata = d; tick = t;
    @(negedge clk);
    we = 0; tick = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1, a, d, 0);
  endtask

  task automatic tk();
    drive(0, addr, wdata, 1);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #2;
    check(tag, rdata, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick = 0; we = 0; addr = 8'h00; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R8 reset state
    rd(8'h20, 0, "R8 load after reset");
    rd(8'h24, 0, "R8 cur after reset");
    rd(8'h30, 0, "R8 status after reset");
    check("R8 irq after reset", {31'd0, irq}, 0);

    // R1 / R2 load and readback
    wr(8'h20, 32'd3);
    rd(8'h20, 32'd3, "R1 load readback");
    rd(8'h24, 32'd3, "R2 cur after load");

    // R3 disabled ticks ignored
    tk(); tk();
    rd(8'h24, 32'd3, "R3 ticks ignored when disabled");

    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, 32'd1, "R8 enable reads bit0 only");
    wr(8'h2C, 1); wr(8'h50, 1);
    tk();
    rd(8'h24, 32'd2, "R3 one step per tick");
    tk();
    rd(8'h30, 0, "R4 no flag at count 1");
    tk();
    rd(8'h24, 0, "R4 count at zero");
    rd(8'h30, 1, "R4 flag set on reaching zero");
    check("R6 irq raised", {31'd0, irq}, 1);
    check("R7 wake raised", {31'd0, wake}, 1);
    tk();
    rd(8'h24, 0, "R4 count stays zero");

    // R5 clear behaviour
    wr(8'h30, 32'hFFFF_FFFE);
    rd(8'h30, 1, "R5 write 0 keeps flag");
    wr(8'h30, 1);
    rd(8'h30, 0, "R5 write 1 clears flag");
    check("R6 irq dropped", {31'd0, irq}, 0);

    // re-arm order: disable, zero, gap, enable; zero count never flags
    wr(8'h28, 0); wr(8'h20, 0);
    wr(8'h28, 1);
    tk();
    rd(8'h30, 0, "R4 zero count gives no flag");
    wr(8'h28, 0); wr(8'h20, 2); wr(8'h28, 1);

    // R6 / R7 gate independence
    wr(8'h2C, 0);
    tk(); tk();
    check("R6 irq gated off", {31'd0, irq}, 0);
    check("R7 wake still on", {31'd0, wake}, 1);
    wr(8'h2C, 1); wr(8'h50, 0);
    check("R7 wake gated off", {31'd0, wake}, 0);
    check("R6 irq on again", {31'd0, irq}, 1);
    wr(8'h30, 1);

    // R5 set wins over same-cycle clear
    wr(8'h20, 1);
    @(negedge clk);
    we = 1; addr = 8'h30; wdata = 1; tick = 1;
    @(negedge clk);
    we = 0; tick = 0;
    rd(8'h30, 1, "R5 set wins over clear");
    wr(8'h30, 1);

    // R1 load beats tick in same cycle
    drive(1, 8'h20, 32'd9, 1);
    rd(8'h24, 32'd9, "R1 load beats tick");

    // wide value
    wr(8'h20, 32'hFFFF_FFFF);
    tk();
    rd(8'h24, 32'hFFFF_FFFE, "R3 wide decrement");

    // R8 unmapped ignored
    wr(8'h04, 32'h1234_5678);
    rd(8'h04, 0, "R8 unmapped reads zero");
    rd(8'h24, 32'hFFFF_FFFE, "R8 unmapped write no effect");

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] offs [7];
      logic [31:0] d;
      offs = '{8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h50, 8'h44};
      d = ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 5));
      @(negedge clk);
      we    = ($urandom_range(0, 2) == 0);
      addr  = offs[$urandom_range(0, 6)];
      wdata = d;
      tick  = ($urandom_range(0, 1) == 1);
    end
    @(negedge clk);
    we = 0; tick = 0;
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule